// File: doc/BRIEF.md
# Memory Block Access Checker

This block sits in front of one slave memory and decides, for every bus access, whether it may proceed. The memory is split into equal power-of-two blocks. For each domain and each block a small table entry holds a 3-bit selector and a world-swap bit. The selector picks one of eight shared permission words. Each permission word grants execute, write and read separately to four combinations of security and privilege. The response comes one cycle after the access strobe, with an error-event pulse whenever the access is refused.

All tables are programmed through a single-cycle write port. A sticky enable turns on checking; until it is set, every access passes. The world-swap bits can be set or cleared 32 blocks at a time for a chosen set of domains. The word index of this bulk update can step forward by itself after each update.

Top module: `mem_block_checker`

## Requirements
- R1: After reset, `rsp_valid` and `err_evt` are low, checking is off, all permission words are zero and all table entries are zero.
- R2: While checking is off, every access is allowed, including one whose address lies beyond the last block.
- R3: A configuration write with `cfg_addr[11:10]`=0 and `cfg_wdata[0]`=1 turns checking on. Checking then stays on until reset, and a later write of 0 has no effect.
- R4: A permission write (`cfg_addr[11:10]`=1, word index in `cfg_addr[2:0]`) stores the grant bits at fixed positions. Bits 0..2 give execute, write and read to non-secure user. Bits 4..6 give them to non-secure privileged, bits 8..10 to secure user and bits 12..14 to secure privileged. Bits 3, 7 and 11 are ignored.
- R5: An instruction fetch (`acc_instr`=1) is checked against the execute bit. Otherwise a write (`acc_write`=1) is checked against the write bit, and a data read against the read bit.
- R6: A table write (`cfg_addr[11:10]`=2) targets the entry addressed by `cfg_addr[7:0]`={domain, block}. It stores the selector from `cfg_wdata[2:0]` and the world-swap bit from `cfg_wdata[3]`. An access uses the permission word that its own domain's entry for the addressed block selects.
- R7: With the world-swap bit clear, secure accesses are checked and non-secure accesses are denied. With it set, non-secure accesses are checked and secure accesses are denied.
- R8: The block index is the address shifted right by `BLK_SHIFT`. With checking on, an index of `NUM_BLK` or more is denied, and the last block (`NUM_BLK`-1) is checked normally.
- R9: Setting bit 31 of a write to permission word 0 locks that word. Later writes to word 0 are ignored until reset, and the other words stay writable.
- R10: Bulk writes use `cfg_addr[11:10]`=3. With `cfg_addr[1:0]`=0 the write sets the word index from `cfg_wdata[0]`, the domain mask from `cfg_wdata[11:8]` and auto-increment from `cfg_wdata[31]`. With 1 it sets, and with 2 it clears, the world-swap bit of block 32*index+k, for every k where `cfg_wdata[k]`=1 and every masked domain. With auto-increment on, the index then advances and wraps.
- R11: `rsp_valid` follows `acc_valid` by one cycle. `rsp_allow` gives the verdict, and `err_evt` pulses in exactly the response cycles that deny.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access strobe |
| acc_addr | input | ADDR_W | Access address within the slave |
| acc_did | input | DID_W | Domain of the requester |
| acc_secure | input | 1 | 1 = secure access |
| acc_priv | input | 1 | 1 = privileged access |
| acc_instr | input | 1 | 1 = instruction fetch |
| acc_write | input | 1 | 1 = write, 0 = read |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 12 | Configuration target |
| cfg_wdata | input | 32 | Configuration data |
| rsp_valid | output | 1 | Response present |
| rsp_allow | output | 1 | 1 = access allowed |
| err_evt | output | 1 | Deny pulse |

## Verification
The assertions check several rules on every cycle. They check that the enable is sticky and that the locked word 0 never changes. They check that a response follows every strobe and only a strobe, that everything passes while checking is off, and that out-of-range and wrong-world secure accesses are refused. The finer behaviour shows only in the bench's scenarios. This covers the grant bit positions, the execute/write/read choice and the per-domain selection of permission words. It also covers the masks, index and wrap of the bulk world-swap update, which the bench compares against its reference model.

// File: rtl/mem_block_checker.sv
module mem_block_checker #(
  parameter int ADDR_W    = 18,
  parameter int BLK_SHIFT = 10,
  parameter int NUM_BLK   = 64,
  parameter int DID_W     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DID_W-1:0]  acc_did,
  input  logic              acc_secure,
  input  logic              acc_priv,
  input  logic              acc_instr,
  input  logic              acc_write,
  input  logic              cfg_we,
  input  logic [11:0]       cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic              rsp_valid,
  output logic              rsp_allow,
  output logic              err_evt
);
  localparam int NUM_DOM = 1 << DID_W;
  localparam int BLK_W   = $clog2(NUM_BLK);
  localparam int IDX_W   = ADDR_W - BLK_SHIFT;
  localparam int NENT    = NUM_DOM * NUM_BLK;
  localparam int NWORD   = (NUM_BLK + 31) / 32;
  localparam int WIDX_W  = (NWORD > 1) ? $clog2(NWORD) : 1;

  logic [11:0]        pol [8];
  logic               lock0, gvalid;
  logic [2:0]         sel_t [NENT];
  logic               nse_t [NENT];
  logic [WIDX_W-1:0]  bidx;
  logic [NUM_DOM-1:0] bdom;
  logic               bauto;

  wire [1:0] kind = cfg_addr[11:10];
  wire [2:0] pidx = cfg_addr[2:0];
  wire       bulk_op = cfg_we && kind == 2'd3 && (cfg_addr[1:0] == 2'd1 || cfg_addr[1:0] == 2'd2);

  wire [IDX_W-1:0]       blk      = acc_addr[ADDR_W-1:BLK_SHIFT];
  wire                   in_range = 32'(blk) < NUM_BLK;
  wire [DID_W+BLK_W-1:0] ent      = {acc_did, blk[BLK_W-1:0]};
  wire [11:0]            word     = pol[sel_t[ent]];
  wire [1:0]             op       = acc_instr ? 2'd0 : (acc_write ? 2'd1 : 2'd2);
  wire [3:0]             gidx     = {2'b00, acc_secure, acc_priv} * 4'd3 + {2'b00, op};
  wire                   world_ok = nse_t[ent] ? !acc_secure : acc_secure;
  wire                   pass     = !gvalid || (in_range && world_ok && word[gidx]);

  assign err_evt = rsp_valid && !rsp_allow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gvalid    <= 1'b0;
      lock0     <= 1'b0;
      bidx      <= '0;
      bdom      <= '0;
      bauto     <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_allow <= 1'b0;
      for (int i = 0; i < 8; i++) pol[i] <= '0;
    end else begin
      rsp_valid <= acc_valid;
      rsp_allow <= acc_valid && pass;
      if (cfg_we) begin
        case (kind)
          2'd0: if (cfg_wdata[0]) gvalid <= 1'b1;
          2'd1: if (!(pidx == 3'd0 && lock0)) begin
                  pol[pidx] <= {cfg_wdata[14:12], cfg_wdata[10:8], cfg_wdata[6:4], cfg_wdata[2:0]};
                  if (pidx == 3'd0) lock0 <= cfg_wdata[31];
                end
          2'd3: if (cfg_addr[1:0] == 2'd0) begin
                  bidx  <= cfg_wdata[WIDX_W-1:0];
                  bdom  <= cfg_wdata[8+NUM_DOM-1:8];
                  bauto <= cfg_wdata[31];
                end else if (bulk_op && bauto) begin
                  bidx <= (32'(bidx) == NWORD - 1) ? '0 : bidx + 1'b1;
                end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < NENT; e++) begin
        sel_t[e] <= '0;
        nse_t[e] <= 1'b0;
      end
    end else begin
      for (int e = 0; e < NENT; e++) begin
        if (cfg_we && kind == 2'd2 && 32'(cfg_addr[DID_W+BLK_W-1:0]) == e) begin
          sel_t[e] <= cfg_wdata[2:0];
          nse_t[e] <= cfg_wdata[3];
        end else if (bulk_op && bdom[e / NUM_BLK] && 32'(bidx) == (e % NUM_BLK) / 32
                     && cfg_wdata[(e % NUM_BLK) % 32]) begin
          nse_t[e] <= (cfg_addr[1:0] == 2'd1);
        end
      end
    end
  end

  assert_gv_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    gvalid |=> gvalid);
  assert_lock_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lock0 |=> lock0 && $stable(pol[0]));
  assert_off_allow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !gvalid) |=> rsp_allow);
  assert_out_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && gvalid && !in_range) |=> (rsp_valid && !rsp_allow));
  assert_nse_secure_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && gvalid && acc_secure && nse_t[ent]) |=> err_evt);
  assert_rsp_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> rsp_valid);
  assert_rsp_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> (!rsp_valid && !err_evt));
endmodule

// File: tb/mem_block_checker_test.sv
module mem_block_checker_test;
  logic clk = 0, rst_n = 0;
  logic acc_valid = 0, acc_secure = 0, acc_priv = 0, acc_instr = 0, acc_write = 0;
  logic [17:0] acc_addr = 0;
  logic [1:0]  acc_did = 0;
  logic        cfg_we = 0;
  logic [11:0] cfg_addr = 0;
  logic [31:0] cfg_wdata = 0;
  logic rsp_valid, rsp_allow, err_evt;

  int checks = 0, fails = 0;

  mem_block_checker uut (.*);

  always #4 clk = ~clk;

  // reference model
  bit          m_gv, m_lk, m_ba, m_bi;
  bit [31:0]   m_pol [8];
  bit [2:0]    m_sel [256];
  bit          m_nse [256];
  bit [3:0]    m_bd;
  bit          exp_v, exp_a;

  function automatic bit model_allow(int addr, int did, bit s, bit p, bit ins, bit wr);
    int b, e, pos;
    if (!m_gv) return 1;
    b = addr / 1024;
    if (b >= 64) return 0;
    e = did * 64 + b;
    if (m_nse[e] == s) return 0;
    pos = (s ? 8 : 0) + (p ? 4 : 0) + (ins ? 0 : (wr ? 1 : 2));
    return m_pol[m_sel[e]][pos];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_gv = 0; m_lk = 0; m_ba = 0; m_bi = 0; m_bd = 0; exp_v = 0; exp_a = 0;
      foreach (m_pol[i]) m_pol[i] = 0;
      foreach (m_sel[i]) begin m_sel[i] = 0; m_nse[i] = 0; end
    end else begin
      exp_v = acc_valid;
      exp_a = acc_valid && model_allow(acc_addr, acc_did, acc_secure, acc_priv, acc_instr, acc_write);
      if (cfg_we) begin
        case (cfg_addr[11:10])
          0: if (cfg_wdata[0]) m_gv = 1;
          1: if (!(cfg_addr[2:0] == 0 && m_lk)) begin
               m_pol[cfg_addr[2:0]] = cfg_wdata & 32'h7777;
               if (cfg_addr[2:0] == 0) m_lk = cfg_wdata[31];
             end
          2: begin m_sel[cfg_addr[7:0]] = cfg_wdata[2:0]; m_nse[cfg_addr[7:0]] = cfg_wdata[3]; end
          3: if (cfg_addr[1:0] == 0) begin
               m_bi = cfg_wdata[0]; m_bd = cfg_wdata[11:8]; m_ba = cfg_wdata[31];
             end else if (cfg_addr[1:0] != 3) begin
               for (int d = 0; d < 4; d++)
                 if (m_bd[d])
                   for (int k = 0; k < 32; k++)
                     if (cfg_wdata[k]) m_nse[d*64 + m_bi*32 + k] = (cfg_addr[1:0] == 1);
               if (m_ba) m_bi = !m_bi;
             end
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (rsp_valid !== exp_v || rsp_allow !== exp_a || err_evt !== (exp_v && !exp_a)) begin
        fails++;
        $display("FAIL R11 model: valid/allow/err=%b%b%b expected %b%b%b",
                 rsp_valid, rsp_allow, err_evt, exp_v, exp_a, exp_v && !exp_a);
      end
    end
  end

  task automatic cfg(input [11:0] a, input [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic acc(input int blk, input int did, input bit s, input bit p, input bit ins,
                     input bit wr, input bit exp, input string tag);
    @(negedge clk);
    acc_valid = 1; acc_addr = 18'(blk * 1024 + 12); acc_did = 2'(did);
    acc_secure = s; acc_priv = p; acc_instr = ins; acc_write = wr;
    @(negedge clk);
    acc_valid = 0;
    checks++;
    if (rsp_valid !== 1'b1 || rsp_allow !== exp || err_evt !== !exp) begin
      fails++;
      $display("FAIL %s: allow=%b err=%b expected allow=%b", tag, rsp_allow, err_evt, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (rsp_valid !== 0 || err_evt !== 0) begin
      fails++; $display("FAIL R1: valid=%b err=%b expected 0 0", rsp_valid, err_evt);
    end
    rst_n = 1;
    acc(0, 0, 1, 1, 0, 0, 1, "R1 reset allow");
    acc(100, 3, 0, 0, 1, 0, 1, "R2 off out-of-range");
    cfg(12'h000, 32'h1);
    acc(0, 0, 1, 1, 0, 0, 0, "R4 zero word deny");
    cfg(12'h000, 32'h0);
    acc(0, 0, 1, 1, 0, 0, 0, "R3 sticky enable");
    cfg(12'h401, 32'h0000_4888);
    cfg(12'h803, 32'h1);
    acc(3, 0, 1, 1, 0, 0, 1, "R6 selected word read");
    acc(3, 0, 1, 1, 0, 1, 0, "R5 write bit");
    acc(3, 0, 1, 1, 1, 0, 0, "R5 exec bit");
    acc(3, 1, 1, 1, 0, 0, 0, "R6 other domain");
    acc(3, 0, 1, 0, 0, 0, 0, "R4 secure user group");
    cfg(12'h402, 32'h0000_0001);
    cfg(12'h885, 32'h0000_000A);
    acc(5, 2, 0, 0, 1, 0, 1, "R7 nse nonsecure exec");
    acc(5, 2, 1, 1, 1, 0, 0, "R7 nse secure deny");
    acc(5, 2, 0, 0, 0, 0, 0, "R5 read bit");
    cfg(12'h403, 32'h0000_7777);
    cfg(12'h847, 32'h3);
    acc(7, 1, 0, 1, 0, 1, 0, "R7 nonsecure without nse");
    acc(7, 1, 1, 0, 0, 1, 1, "R4 secure user write");
    cfg(12'h83F, 32'h3);
    acc(63, 0, 1, 1, 0, 1, 1, "R8 last block");
    acc(64, 0, 1, 1, 0, 1, 0, "R8 past last block");
    cfg(12'h400, 32'h8000_2000);
    cfg(12'h400, 32'h0000_7777);
    acc(10, 3, 1, 1, 0, 1, 1, "R9 locked write grant");
    acc(10, 3, 1, 1, 0, 0, 0, "R9 rewrite ignored");
    cfg(12'h404, 32'h0000_4000);
    cfg(12'h8CA, 32'h4);
    acc(10, 3, 1, 1, 0, 0, 1, "R9 other word writable");
    cfg(12'h828, 32'h3);
    cfg(12'h868, 32'h3);
    cfg(12'hC00, 32'h8000_0101);
    cfg(12'hC01, 32'h0000_0100);
    acc(40, 0, 0, 1, 0, 0, 1, "R10 masked domain set");
    acc(40, 1, 0, 1, 0, 0, 0, "R10 unmasked domain");
    cfg(12'hC01, 32'h0000_0008);
    acc(3, 0, 1, 1, 0, 0, 0, "R10 auto-increment wrap");
    cfg(12'hC02, 32'h0000_0100);
    acc(40, 0, 0, 1, 0, 0, 0, "R10 clear nonsecure");
    acc(40, 0, 1, 1, 0, 0, 1, "R10 clear secure");
    @(negedge clk); acc_valid = 1; acc_addr = 18'h0; acc_did = 0; acc_secure = 0;
    @(negedge clk); acc_addr = 18'(3 * 1024);
    @(negedge clk); acc_valid = 0;
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule